// File: doc/BRIEF.md
# Microsecond Event Timer (One-Shot / Periodic)

This block is a down-counting event timer. It advances on a one-microsecond tick enable that the surrounding logic supplies. Software controls it by writing two 32-bit words. The control word carries three fields: a run flag, a repeat flag and a 29-bit reload value. Writing the control word loads the counter at once and restarts the countdown. The status word shows the live count and the pending interrupt. A write of one to its clear bit drops the interrupt.

When the count has reached zero, the next tick is the expiry. Expiry raises a level-high interrupt. In one-shot mode the run flag then clears itself and the counter stays at zero. In repeat mode the counter reloads on that same tick and keeps going. A programmed value of V therefore gives an interval of V+1 ticks. Writing zero to the control word stops the timer.

Top module: `usec_event_timer`

## Requirements
- R1: After a synchronous active-low reset, `irq` is 0 and both `ctrl_q` and `stat_q` read 0.
- R2: A control write (`wr_en`=1, `wr_sel`=0) stores bit 31 as the run flag, bit 30 as the repeat flag and bits [28:0] as the reload value. `ctrl_q` returns these fields in the same positions, with the other bits 0. The same write loads bits [28:0] into the counter.
- R3: While running, the counter decrements by one only in cycles where `tick_en` is 1. Without a tick it holds its value.
- R4: In one-shot mode (bit 31 set, bit 30 clear), expiry happens on the tick taken while the count is 0, which is the (V+1)-th tick after loading V. Expiry sets `irq`, clears the run flag (`ctrl_q[31]` reads 0) and leaves the count at 0.
- R5: In repeat mode (bits 31 and 30 set), the expiry tick reloads the counter with V and sets `irq`. The timer then fires again every V+1 ticks.
- R6: `irq` stays at 1 until a status write (`wr_en`=1, `wr_sel`=1) has bit 30 set. A status write with bit 30 clear leaves `irq` unchanged.
- R7: If an expiry and a clearing status write fall in the same cycle, `irq` is 1 afterwards.
- R8: While the run flag is 0, ticks change neither the count nor `irq`. A control write of zero stops a running timer.
- R9: A control write with the run flag set while the timer is running restarts the countdown from the new value.
- R10: `stat_q` returns the count in bits [28:0] and `irq` in bit 30, with the other bits 0.
- R11: In repeat mode with V=0, every tick is an expiry.
- R12: A control write in the same cycle as a tick takes precedence. The counter holds the written value and no expiry happens in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_en | input | 1 | One-microsecond tick enable, one cycle wide |
| wr_en | input | 1 | Write strobe |
| wr_sel | input | 1 | Write target: 0 is the control word, 1 is the status word |
| wr_data | input | 32 | Write data |
| ctrl_q | output | 32 | Control word readback |
| stat_q | output | 32 | Status word: count and pending interrupt |
| irq | output | 1 | Level-high interrupt |

## Verification
A wrong count shows at once in `stat_q`, in the cycle after the faulty tick or write. It also shifts the expiry, so `irq` rises one or more ticks early or late. A wrong run flag or repeat flag shows in `ctrl_q` straight after the expiry tick. It then shows again at the next expected interval, as a missing reload or an extra firing. A fault in the interrupt latch appears within one cycle of a clear write or an expiry. The coincident expiry-and-clear case is aimed at the one cycle where precedence matters.

// File: rtl/uet_pkg.sv
// Package: shared constants for the microsecond event timer.
// Assumes a 32-bit register word. The field positions below are fixed
// because software encodes them.
package uet_pkg;
    localparam int WORD_W  = 32;
    localparam int CNT_W   = 29;
    localparam int RUN_BIT = 31;
    localparam int REP_BIT = 30;
    localparam int CLR_BIT = 30;
endpackage

// File: rtl/uet_ctrl_reg.sv
// Module: uet_ctrl_reg
// Holds the run flag, the repeat flag and the reload value.
// Assumes the write is a single-cycle strobe and that expiry comes from the counter.
// A write takes precedence over a self-clear caused by expiry.
module uet_ctrl_reg #(
    parameter int WORD_W  = 32,
    parameter int CNT_W   = 29,
    parameter int RUN_BIT = 31,
    parameter int REP_BIT = 30
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [WORD_W-1:0] wdata,
    input  logic              expire,
    output logic              run,
    output logic              rep,
    output logic [CNT_W-1:0]  reload
);
    // Control fields: load on write, drop the run flag after a one-shot expiry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run    <= 1'b0;
            rep    <= 1'b0;
            reload <= '0;
        end else if (wr) begin
            run    <= wdata[RUN_BIT];
            rep    <= wdata[REP_BIT];
            reload <= wdata[CNT_W-1:0];
        end else if (expire && !rep) begin
            run    <= 1'b0;
        end
    end

    AST_ONESHOT_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        (expire && !rep && !wr) |=> !run); // R4
    AST_REPEAT_KEEPS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        (expire && rep && !wr) |=> run); // R5
endmodule

// File: rtl/uet_counter.sv
// Module: uet_counter
// The down counter. It decrements on ticks while running, detects expiry at a
// count of zero, and reloads there in repeat mode. Assumes the tick is one cycle
// wide and that a load is a control write, which takes precedence over any tick.
module uet_counter #(
    parameter int CNT_W = 29
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             rep,
    input  logic [CNT_W-1:0] reload,
    input  logic             tick,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic [CNT_W-1:0] count,
    output logic             expire
);
    logic at_zero;

    // Expiry detect: a tick while running at zero, with no competing load.
    always_comb begin
        at_zero = (count == '0);
        expire  = run && tick && !load && at_zero;
    end

    // Count state: a load wins, then reload or hold at expiry, otherwise step down on a tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else if (load) begin
            count <= load_val;
        end else if (expire) begin
            count <= rep ? reload : '0;
        end else if (run && tick) begin
            count <= count - 1'b1;
        end
    end

    AST_NO_TICK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !load) |=> $stable(count)); // R3
    AST_STOPPED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !load) |=> $stable(count)); // R8
    AST_REPEAT_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (expire && rep) |=> (count == $past(reload))); // R5
    AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (count == $past(load_val))); // R12
endmodule

// File: rtl/uet_irq_latch.sv
// Module: uet_irq_latch
// The level interrupt latch. Expiry sets it and a write-one clear resets it.
// Assumes clr is already qualified by the status write strobe. Expiry takes
// precedence over a clear in the same cycle.
module uet_irq_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic expire,
    input  logic clr,
    output logic irq
);
    // Pending flag: set on expiry, else clear on request.
    always_ff @(posedge clk) begin
        if (!rst_n)      irq <= 1'b0;
        else if (expire) irq <= 1'b1;
        else if (clr)    irq <= 1'b0;
    end

    AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !clr) |=> irq); // R6
    AST_CLEAR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !expire) |=> !irq); // R6
    AST_EXPIRE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> irq); // R7
endmodule

// File: rtl/usec_event_timer.sv
// Module: usec_event_timer
// Top level of the one-shot / periodic microsecond event timer. It decodes
// writes to the control and status words and builds both readback words.
// Assumes tick_en comes from an external 1 MHz enable generator in the clk domain.
module usec_event_timer
    import uet_pkg::*;
#(
    parameter int DW  = WORD_W,
    parameter int CW  = CNT_W,
    parameter int RB  = RUN_BIT,
    parameter int PB  = REP_BIT,
    parameter int CB  = CLR_BIT
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick_en,
    input  logic          wr_en,
    input  logic          wr_sel,
    input  logic [DW-1:0] wr_data,
    output logic [DW-1:0] ctrl_q,
    output logic [DW-1:0] stat_q,
    output logic          irq
);
    localparam int CTRL_PAD = PB - CW;
    localparam int STAT_HI  = DW - CB - 1;
    localparam int STAT_LO  = CB - CW;

    logic          ctrl_wr;
    logic          clr_req;
    logic          run;
    logic          rep;
    logic [CW-1:0] reload;
    logic [CW-1:0] count;
    logic          expire;

    // Write decode: select the target word and qualify the clear bit.
    always_comb begin
        ctrl_wr = wr_en && !wr_sel;
        clr_req = wr_en && wr_sel && wr_data[CB];
    end

    uet_ctrl_reg #(.WORD_W(DW), .CNT_W(CW), .RUN_BIT(RB), .REP_BIT(PB)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .wr(ctrl_wr), .wdata(wr_data),
        .expire(expire), .run(run), .rep(rep), .reload(reload)
    );

    uet_counter #(.CNT_W(CW)) u_cnt (
        .clk(clk), .rst_n(rst_n), .run(run), .rep(rep), .reload(reload),
        .tick(tick_en), .load(ctrl_wr), .load_val(wr_data[CW-1:0]),
        .count(count), .expire(expire)
    );

    uet_irq_latch u_irq (
        .clk(clk), .rst_n(rst_n), .expire(expire), .clr(clr_req), .irq(irq)
    );

    // Readback words: fields in their software-visible positions, other bits zero.
    always_comb begin
        ctrl_q = {run, rep, {CTRL_PAD{1'b0}}, reload};
        stat_q = {{STAT_HI{1'b0}}, irq, {STAT_LO{1'b0}}, count};
    end

    AST_STAT_IRQ_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_q[CB] == irq)); // R10
    AST_STOPPED_NO_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !irq) |=> !irq); // R8
endmodule

// File: tb/usec_event_timer_test.sv
module usec_event_timer_test;
    localparam int CLK_PERIOD = 10;

    typedef struct packed {
        logic [1:0]  kind;    // 0 control write, 1 status write, 2 ticks
        logic [31:0] data;
        logic [7:0]  n;
        logic        e_irq;
        logic [28:0] e_cnt;
    } vec_t;

    localparam int NV = 17;
    localparam vec_t VECS [NV] = '{
        '{2'd0, 32'h8000_0004, 8'd0, 1'b0, 29'd4}, // R2 load one-shot 4
        '{2'd2, 32'h0,         8'd3, 1'b0, 29'd1}, // R3
        '{2'd2, 32'h0,         8'd1, 1'b0, 29'd0}, // R3
        '{2'd2, 32'h0,         8'd1, 1'b1, 29'd0}, // R4 fifth tick expires
        '{2'd2, 32'h0,         8'd2, 1'b1, 29'd0}, // R4 stopped
        '{2'd1, 32'h0,         8'd0, 1'b1, 29'd0}, // R6 write 0 ignored
        '{2'd1, 32'h4000_0000, 8'd0, 1'b0, 29'd0}, // R6 clear
        '{2'd0, 32'hC000_0002, 8'd0, 1'b0, 29'd2}, // R5 repeat 2
        '{2'd2, 32'h0,         8'd3, 1'b1, 29'd2}, // R5 expiry reloads
        '{2'd1, 32'h4000_0000, 8'd0, 1'b0, 29'd2}, // R6
        '{2'd2, 32'h0,         8'd2, 1'b0, 29'd0}, // R5
        '{2'd2, 32'h0,         8'd1, 1'b1, 29'd2}, // R5 second period
        '{2'd0, 32'h8000_0007, 8'd0, 1'b1, 29'd7}, // R9 restart
        '{2'd0, 32'h0000_0000, 8'd0, 1'b1, 29'd0}, // R8 stop
        '{2'd2, 32'h0,         8'd5, 1'b1, 29'd0}, // R8
        '{2'd1, 32'h4000_0000, 8'd0, 1'b0, 29'd0}, // R6
        '{2'd0, 32'h0000_0005, 8'd0, 1'b0, 29'd5}  // R8 loaded, not running
    };

    logic        clk = 1'b0;
    logic        rst_n;
    logic        tick_en;
    logic        wr_en;
    logic        wr_sel;
    logic [31:0] wr_data;
    logic [31:0] ctrl_q;
    logic [31:0] stat_q;
    logic        irq;

    int tests = 0;
    int fails = 0;

    usec_event_timer uut (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .wr_en(wr_en),
        .wr_sel(wr_sel), .wr_data(wr_data), .ctrl_q(ctrl_q), .stat_q(stat_q), .irq(irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic step(input logic w, input logic sel, input logic [31:0] d, input logic t);
        @(negedge clk);
        wr_en = w; wr_sel = sel; wr_data = d; tick_en = t;
        @(posedge clk);
        #1;
        wr_en = 1'b0; tick_en = 1'b0; wr_data = '0;
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        rst_n = 1'b0; tick_en = 1'b0; wr_en = 1'b0; wr_sel = 1'b0; wr_data = '0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        check("R1 irq", {31'd0, irq}, 32'd0);
        check("R1 ctrl", ctrl_q, 32'd0);
        check("R1 stat", stat_q, 32'd0);

        for (int i = 0; i < NV; i++) begin
            case (VECS[i].kind)
                2'd0: step(1'b1, 1'b0, VECS[i].data, 1'b0);
                2'd1: step(1'b1, 1'b1, VECS[i].data, 1'b0);
                default: for (int k = 0; k < int'(VECS[i].n); k++) step(1'b0, 1'b0, '0, 1'b1);
            endcase
            check($sformatf("vec%0d R2-R9 count", i), {3'd0, stat_q[28:0]}, {3'd0, VECS[i].e_cnt});
            check($sformatf("vec%0d R6 irq", i), {31'd0, irq}, {31'd0, VECS[i].e_irq});
        end

        // R2 readback of fields and R10 status layout
        step(1'b1, 1'b0, 32'hFFFF_FFFF, 1'b0);
        check("R2 ctrl readback", ctrl_q, 32'hDFFF_FFFF);
        check("R10 stat layout", stat_q, 32'h1FFF_FFFF);
        step(1'b1, 1'b0, 32'h0, 1'b0);

        // R4 one-shot from zero: run flag clears itself
        step(1'b1, 1'b0, 32'h8000_0000, 1'b0);
        step(1'b0, 1'b0, '0, 1'b1);
        check("R4 run cleared", ctrl_q, 32'h0);
        check("R10 irq in stat", stat_q, 32'h4000_0000);
        step(1'b1, 1'b1, 32'h4000_0000, 1'b0);

        // R3 no ticks: count holds
        step(1'b1, 1'b0, 32'h8000_0003, 1'b0);
        repeat (4) step(1'b0, 1'b0, '0, 1'b0);
        check("R3 hold without tick", stat_q, 32'h3);

        // R11 repeat with zero: every tick fires
        step(1'b1, 1'b0, 32'hC000_0000, 1'b0);
        step(1'b0, 1'b0, '0, 1'b1);
        check("R11 first tick fires", {31'd0, irq}, 32'd1);
        step(1'b1, 1'b1, 32'h4000_0000, 1'b0);
        check("R6 cleared", {31'd0, irq}, 32'd0);
        step(1'b0, 1'b0, '0, 1'b1);
        check("R11 next tick fires", {31'd0, irq}, 32'd1);

        // R7 expiry and clear in the same cycle
        step(1'b1, 1'b1, 32'h4000_0000, 1'b1);
        check("R7 expiry beats clear", {31'd0, irq}, 32'd1);
        step(1'b1, 1'b1, 32'h4000_0000, 1'b0);

        // R12 control write together with a tick: write wins, no expiry
        step(1'b1, 1'b0, 32'h8000_0003, 1'b1);
        check("R12 count", stat_q, 32'h3);
        check("R12 no irq", {31'd0, irq}, 32'd0);

        // R1 reset mid-run
        @(negedge clk) rst_n = 1'b0;
        @(posedge clk); #1 rst_n = 1'b1;
        check("R1 reset ctrl", ctrl_q, 32'h0);
        check("R1 reset stat", stat_q, 32'h0);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule